// File: doc/BRIEF.md
# Level-Tracking Interrupt Aggregator with Retrigger

This block merges a set of active-high, level-held bus interrupt request lines into a pending-status view and produces one interrupt line for a processor that only reacts to rising edges. Every request passes through a two-flop synchronizer. The synchronized level becomes the pending bit directly, so a bit clears by itself as soon as its source drops the request. No software write is needed to clear it. There are two request groups. The main group has eight lines and is always active. The extra group has three lines, and a control bit gates it off completely.

The output stays high while anything is pending. Software can use a retrigger command, a self-clearing control bit, to pull the output low for a fixed number of clock cycles. When that window ends, the output is evaluated again. If a request is still outstanding, for example one that arrived while an earlier one was being serviced, the processor sees a fresh rising edge. A mode bit picks one of two output behaviours. In auto-clear mode the output falls on its own once nothing is pending. In the other mode the output holds high until a retrigger.

Top module: `irq_level_agg`

## Requirements
- R1: Main request line i (bit order: bus IRQ3, IRQ4, IRQ5, IRQ6, IRQ7, IRQ10, IRQ11, IRQ12 on bits 0..7) shows as bit i of the read data at address 1 from the second rising clock edge after the line changes, and it clears the same way when the line drops.
- R2: Extra request lines (bits 0..2 at address 2: IRQ9, IRQ14, IRQ15) read as 0 and never raise the output while control bit 2 (extra-group enable) is 0. Once that bit is 1, they behave like the main lines.
- R3: With control bit 1 (auto-clear) set and no retrigger window running, the output equals the OR of all pending bits, one clock after the pending state. It falls by itself once no bit is pending.
- R4: With auto-clear at 0 and no retrigger window running, the output rises when any bit is pending and then stays high, even after every request drops, until a retrigger.
- R5: Writing control data with bit 0 (retrigger) set makes the output low from the second edge after the write edge, for exactly PULSE_CYC cycles. After that, the output is re-evaluated from the pending bits and the mode.
- R6: Control bit 0 reads 1 while the retrigger window runs and 0 afterwards. A retrigger write during a running window restarts the full window.
- R7: Writes to addresses 1 and 2 are ignored: control readback, pending bits and the output are unchanged.
- R8: After reset, control reads 0, all pending bits read 0 and the output is 0.
- R9: If a second request becomes pending while the first is still held, the first request dropping causes no falling edge on the output.
- R10: Control reads back bit 2 and bit 1 as written, with bits 7..3 as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_main | input | 8 | Main group request levels |
| req_ext | input | 3 | Extra group request levels |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 main pending, 2 extra pending |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the current address |
| irq_out | output | 1 | Aggregated processor interrupt line |

## Verification
The two functions that can meet in one cycle are the retrigger write and a change in the pending state. The bench drives a retrigger write in the same cycle that a new request line rises. It expects the output to stay low for the full window and then rise on the first cycle after the window. The output must not leak high early from the new request, and the request must not be lost. A second collision rewrites the retrigger partway through a running window. The bench judges this by the output still being low at the cycle where the first window would have ended.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADR_CTRL     = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_PEND_MAIN = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_PEND_EXT  = 2'd2;

  localparam int BIT_RETRIG = 0;
  localparam int BIT_AUTO   = 1;
  localparam int BIT_EXTEN  = 2;

  typedef struct packed {
    logic ext_en;
    logic auto_clr;
  } agg_cfg_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        stab_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= async_in[g];
        stab_q[g] <= meta_q[g];
      end
    end
  end

  assign sync_out = stab_q;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irqagg_pkg::*;
#(
  parameter int PULSE_CYC = 140
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output agg_cfg_t          cfg,
  output logic              pulse_on
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC);

  agg_cfg_t         cfg_q, cfg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ctrl_wr;
  logic             retrig_wr;

  assign ctrl_wr   = wr_en && (addr == ADR_CTRL);
  assign retrig_wr = ctrl_wr && wr_data[BIT_RETRIG];

  always_comb begin
    cfg_d = cfg_q;
    if (ctrl_wr) begin
      cfg_d.auto_clr = wr_data[BIT_AUTO];
      cfg_d.ext_en   = wr_data[BIT_EXTEN];
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (retrig_wr) begin
      cnt_d = CNT_LOAD;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      cnt_q <= cnt_d;
    end
  end

  assign cfg      = cfg_q;
  assign pulse_on = (cnt_q != '0);

  AST_RETRIG_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    retrig_wr |=> (pulse_on && cnt_q == CNT_LOAD)); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LOAD); // R5
  AST_RO_NO_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != ADR_CTRL) |=> $stable(cfg_q)); // R7
endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic any_pend,
  input  logic auto_clr,
  input  logic pulse_on,
  output logic irq_o
);
  logic out_q, out_d;

  always_comb begin
    if (pulse_on) begin
      out_d = 1'b0;
    end else if (auto_clr) begin
      out_d = any_pend;
    end else begin
      out_d = out_q | any_pend;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
    end else begin
      out_q <= out_d;
    end
  end

  assign irq_o = out_q;

  AST_PULSE_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_on |=> !irq_o); // R5
  AST_PEND_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_on && any_pend) |=> irq_o); // R3
  AST_AUTO_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_clr && !pulse_on && !any_pend) |=> !irq_o); // R3
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_clr && !pulse_on && irq_o) |=> irq_o); // R4
endmodule

// File: rtl/irq_level_agg.sv
module irq_level_agg
  import irqagg_pkg::*;
#(
  parameter int N_MAIN    = 8,
  parameter int N_EXT     = 3,
  parameter int PULSE_CYC = 140
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_MAIN-1:0] req_main,
  input  logic [N_EXT-1:0]  req_ext,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_out
);
  logic              rst_meta_q, rst_sn;
  logic [N_MAIN-1:0] pend_main;
  logic [N_EXT-1:0]  sync_ext;
  logic [N_EXT-1:0]  pend_ext;
  agg_cfg_t          cfg;
  logic              pulse_on;
  logic              any_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sn     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sn     <= rst_meta_q;
    end
  end

  irq_sync #(.WIDTH(N_MAIN)) u_sync_main (
    .clk      (clk),
    .rst_n    (rst_sn),
    .async_in (req_main),
    .sync_out (pend_main)
  );

  irq_sync #(.WIDTH(N_EXT)) u_sync_ext (
    .clk      (clk),
    .rst_n    (rst_sn),
    .async_in (req_ext),
    .sync_out (sync_ext)
  );

  assign pend_ext = sync_ext & {N_EXT{cfg.ext_en}};
  assign any_pend = (|pend_main) | (|pend_ext);

  irq_ctrl #(.PULSE_CYC(PULSE_CYC)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sn),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .cfg      (cfg),
    .pulse_on (pulse_on)
  );

  irq_out_gen u_out (
    .clk      (clk),
    .rst_n    (rst_sn),
    .any_pend (any_pend),
    .auto_clr (cfg.auto_clr),
    .pulse_on (pulse_on),
    .irq_o    (irq_out)
  );

  always_comb begin
    rd_data = '0;
    unique case (addr)
      ADR_CTRL: begin
        rd_data[BIT_RETRIG] = pulse_on;
        rd_data[BIT_AUTO]   = cfg.auto_clr;
        rd_data[BIT_EXTEN]  = cfg.ext_en;
      end
      ADR_PEND_MAIN: rd_data[N_MAIN-1:0] = pend_main;
      ADR_PEND_EXT:  rd_data[N_EXT-1:0]  = pend_ext;
      default:       rd_data = '0;
    endcase
  end

  AST_EXT_GATED: assert property (@(posedge clk) disable iff (!rst_sn)
    (!cfg.ext_en && !pulse_on && pend_main == '0 && cfg.auto_clr) |=> !irq_out); // R2
endmodule

// File: tb/irq_level_agg_test.sv
module irq_level_agg_test;
  localparam int P = 140;

  logic       clk;
  logic       rst_n;
  logic [7:0] req_main;
  logic [2:0] req_ext;
  logic       wr_en;
  logic [1:0] addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       irq_out;

  typedef struct {
    int         due;
    bit         is_rd;
    logic [7:0] val;
    string      tag;
  } item_t;

  item_t q[$];
  item_t it;
  int    cyc;
  int    n_run;
  int    n_fail;
  bit    done;

  irq_level_agg #(.PULSE_CYC(P)) uut (
    .clk(clk), .rst_n(rst_n), .req_main(req_main), .req_ext(req_ext),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  // monitor: pops due items and compares
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      logic [7:0] act;
      it = q.pop_front();
      act = it.is_rd ? rd_data : {7'd0, irq_out};
      n_run++;
      if (it.due != cyc || act !== it.val) begin
        n_fail++;
        $display("FAIL %s: %s actual %h expected %h (cycle %0d)",
                 it.tag, it.is_rd ? "rd_data" : "irq_out", act, it.val, cyc);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic exp(input int d, input bit rd, input logic [7:0] v, input string t);
    item_t x;
    x.due = cyc + d; x.is_rd = rd; x.val = v; x.tag = t;
    q.push_back(x);
  endtask

  task automatic wr_go(input logic [1:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; req_main = '0; req_ext = '0; wr_en = 1'b0; addr = 2'd0; wr_data = '0;
    step(3);
    rst_n = 1'b1;
    step(4);
    // R8 reset state
    addr = 2'd0; exp(0, 1, 8'h00, "R8"); exp(0, 0, 8'h00, "R8"); step(1);
    addr = 2'd1; exp(0, 1, 8'h00, "R8"); step(1);
    addr = 2'd2; exp(0, 1, 8'h00, "R8"); step(1);

    // auto-clear mode, R10 readback
    wr_go(2'd0, 8'hF2); step(1); wr_en = 1'b0;
    exp(0, 1, 8'h02, "R10"); step(1);

    // R1 / R3 single request
    addr = 2'd1; req_main = 8'h04;
    exp(1, 1, 8'h00, "R1"); exp(2, 1, 8'h04, "R1"); exp(2, 0, 8'h00, "R3"); exp(3, 0, 8'h01, "R3");
    step(4);
    // R9 overlap: second arrives, first drops
    req_main = 8'h24; step(4);
    req_main = 8'h20;
    exp(2, 1, 8'h20, "R9"); exp(2, 0, 8'h01, "R9"); exp(3, 0, 8'h01, "R9"); exp(5, 0, 8'h01, "R9");
    step(6);
    // drop all -> auto clear
    req_main = 8'h00;
    exp(2, 1, 8'h00, "R1"); exp(2, 0, 8'h01, "R3"); exp(3, 0, 8'h00, "R3");
    step(4);

    // R2 extra group disabled
    addr = 2'd2; req_ext = 3'b111;
    exp(2, 1, 8'h00, "R2"); exp(4, 0, 8'h00, "R2"); step(5);
    wr_go(2'd0, 8'h06); step(1); wr_en = 1'b0;
    addr = 2'd2; exp(0, 1, 8'h07, "R2"); exp(1, 0, 8'h01, "R2"); step(2);
    req_ext = 3'b000; exp(2, 1, 8'h00, "R2"); exp(3, 0, 8'h00, "R2"); step(4);

    // R7 writes to status ignored
    req_main = 8'h01; step(4);
    wr_go(2'd1, 8'hFF); step(1);
    wr_go(2'd2, 8'hF8); step(1); wr_en = 1'b0;
    addr = 2'd0; exp(0, 1, 8'h06, "R7"); exp(0, 0, 8'h01, "R7"); step(1);
    addr = 2'd1; exp(0, 1, 8'h01, "R7"); step(1);
    addr = 2'd2; exp(0, 1, 8'h00, "R7"); step(1);

    // R5 / R6 retrigger with pending request
    wr_go(2'd0, 8'h07);
    exp(1, 1, 8'h07, "R6"); exp(1, 0, 8'h01, "R5"); exp(2, 0, 8'h00, "R5"); exp(2, 1, 8'h07, "R6");
    exp(140, 1, 8'h07, "R6"); exp(141, 0, 8'h00, "R5"); exp(141, 1, 8'h06, "R6"); exp(142, 0, 8'h01, "R5");
    step(1); wr_en = 1'b0; step(143);

    // R6 restart during window
    wr_go(2'd0, 8'h07); exp(2, 0, 8'h00, "R6"); step(1); wr_en = 1'b0; step(49);
    wr_go(2'd0, 8'h07);
    exp(1, 0, 8'h00, "R6"); exp(92, 0, 8'h00, "R6"); exp(141, 0, 8'h00, "R6"); exp(142, 0, 8'h01, "R6");
    step(1); wr_en = 1'b0; step(143);

    // R5 retrigger with nothing pending
    req_main = 8'h00; step(4);
    wr_go(2'd0, 8'h07); exp(2, 0, 8'h00, "R5"); exp(142, 0, 8'h00, "R5"); exp(150, 0, 8'h00, "R5");
    step(1); wr_en = 1'b0; step(151);

    // R4 sticky mode
    wr_go(2'd0, 8'h04); step(1); wr_en = 1'b0;
    req_main = 8'h80; exp(3, 0, 8'h01, "R4"); step(4);
    req_main = 8'h00; exp(3, 0, 8'h01, "R4"); exp(10, 0, 8'h01, "R4"); step(11);
    wr_go(2'd0, 8'h05); exp(2, 0, 8'h00, "R4"); exp(142, 0, 8'h00, "R4"); exp(145, 0, 8'h00, "R4");
    step(1); wr_en = 1'b0; step(146);

    // collision: retrigger write and request arrive in the same cycle
    wr_go(2'd0, 8'h07); req_main = 8'h10;
    exp(2, 0, 8'h00, "R5"); exp(141, 0, 8'h00, "R5"); exp(142, 0, 8'h01, "R5");
    step(1); wr_en = 1'b0; step(143);
    req_main = 8'h00; exp(3, 0, 8'h00, "R3"); step(5);

    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule